// File: doc/BRIEF.md
# Idle Power-State Entry Controller

This block watches a busy/idle indication from a graphics engine and decides when the engine may drop into a low-power sleep state. All of its timing runs on a common slow tick, nominally 1.28 µs, which an internal prescaler derives from the clock. Software programs the block through a single-cycle register write/read port.

Two hardware policies can trigger entry to the normal sleep depth:

- **Interval mode** counts idle ticks over a fixed evaluation window and enters sleep if the count reaches a threshold.
- **Timeout mode** enters sleep once the engine has been idle without a break for a threshold number of ticks.

A software override bypasses both timers and sends the block straight to an encoded depth. A separate hysteresis counter raises a power-gate request after a programmable run of idle ticks. Any busy indication wakes the block at once.

Register map (3-bit address, 32-bit data):

| Address | Contents |
|---|---|
| 0 | Control. Bit 0 = hardware control enable, bit 1 = sleep enable, bit 2 = interval mode, bit 3 = timeout mode. |
| 1 | State. Bits [6:4] = software target (read/write); bits [9:8] = current state (read only). |
| 2 | Evaluation interval, in ticks. |
| 3 | Idle threshold, in ticks. |
| 4 | Idle hysteresis, in ticks. |
| 5 | Wake rate limit: two 16-bit halves. |

Top module: `idle_pwr_ctrl`

## Requirements
- R1: After reset the outputs and registers hold these values:
  - `pstate_o` = 0 and `pg_req_o` = 0.
  - Control and software target read 0.
  - Interval reads 125000, threshold reads 50000, hysteresis reads 25.
  - Wake rate limit reads 54 in bits [31:16] and 85 in bits [15:0].
- R2: Every timer advances only on a tick, one tick every TICK_DIV clocks. The block never leaves the active state between ticks.
- R3: Timeout mode is selected by control = hw, sleep and timeout bits (4'b1011). The block enters state 1 (normal) on the tick at which the continuous idle count reaches the threshold. A busy cycle restarts that count.
- R4: Interval mode is selected by control = hw, sleep and interval bits (4'b0111). At the tick that ends each interval, the block enters state 1 if the idle ticks counted in that interval reached the threshold. The idle count clears at every interval end, whether or not entry happened.
- R5: When both mode bits are set, timeout mode governs entry.
- R6: Hardware entry requires both the hw-control bit and the sleep-enable bit. With sleep-enable clear, the block stays active and `pg_req_o` stays 0.
- R7: When control holds only the sleep-enable bit (4'b0010), the timers are bypassed and the software target selects the depth on the next idle tick:
  - Target 4 gives state 1, target 5 gives state 2, target 6 gives state 3.
  - Any other target keeps the block active.
- R8: A busy cycle in any sleep state returns `pstate_o` to 0 on the next clock edge and clears the idle counters. A new timeout entry then needs the full threshold again.
- R9: With sleep-enable set, `pg_req_o` rises once idle has lasted the hysteresis count of ticks. It falls on the clock edge after a busy cycle.
- R10: Writing 0 to control and to the state register brings the block to state 0 with `pg_req_o` = 0.
- R11: The wake rate limit register stores and returns both 16-bit halves independently.
- R12: The current state reads back in bits [9:8] of the state register and on `pstate_o`, with the same encoding on both: 0 = active, 1 = normal, 2 = deep, 3 = deepest.
- R13: A busy cycle that coincides with the tick on which an entry condition would be met keeps the block active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Engine busy indication |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pstate_o | output | 2 | Current power state |
| pg_req_o | output | 1 | Power-gate request |

## Verification
Two functions can fall in the same cycle: a busy indication and the tick on which a timer would grant entry. The bench first learns the tick phase by using a threshold of one and watching for the first entry. It then holds busy low between ticks and raises it exactly on the next tick. The block must stay active through that tick, and must enter sleep on the next tick once busy is dropped.

// File: rtl/ipc_pkg.sv
`timescale 1ns/1ps
package ipc_pkg;
  typedef enum logic [1:0] {
    PS_ACT     = 2'd0,
    PS_NORM    = 2'd1,
    PS_DEEP    = 2'd2,
    PS_DEEPEST = 2'd3
  } pstate_e;

  localparam int unsigned CB_HW  = 0;
  localparam int unsigned CB_SLP = 1;
  localparam int unsigned CB_EI  = 2;
  localparam int unsigned CB_TO  = 3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_STATE = 3'd1;
  localparam logic [2:0] A_IVAL  = 3'd2;
  localparam logic [2:0] A_THR   = 3'd3;
  localparam logic [2:0] A_HYST  = 3'd4;
  localparam logic [2:0] A_WRL   = 3'd5;

  localparam int unsigned TGT_LSB = 4;
  localparam int unsigned ST_LSB  = 8;
endpackage

// File: rtl/ipc_tick_gen.sv
`timescale 1ns/1ps
module ipc_tick_gen #(
  parameter int unsigned DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [W-1:0] cnt_q;
      assign tick_o = (cnt_q == W'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ipc_idle_timers.sv
`timescale 1ns/1ps
module ipc_idle_timers #(
  parameter int unsigned CW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          idle_i,
  input  logic          clr_i,
  input  logic          hgate_i,
  input  logic [CW-1:0] ival_i,
  input  logic [CW-1:0] thr_i,
  input  logic [CW-1:0] hyst_i,
  output logic          enter_ei_o,
  output logic          enter_to_o,
  output logic          pg_o
);
  logic [CW-1:0] ei_cnt_q, acc_q, run_q, hcnt_q;
  logic [CW-1:0] ei_cnt_n, acc_n, run_n, hcnt_n;
  logic          ei_last, pg_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] x);
    return (&x) ? x : x + 1'b1;
  endfunction

  always_comb begin
    ei_cnt_n   = sat_inc(ei_cnt_q);
    acc_n      = idle_i ? sat_inc(acc_q) : acc_q;
    run_n      = sat_inc(run_q);
    hcnt_n     = sat_inc(hcnt_q);
    ei_last    = (ival_i != '0) && (ei_cnt_n >= ival_i);
    enter_ei_o = tick_i && !clr_i && ei_last && (acc_n >= thr_i);
    enter_to_o = tick_i && !clr_i && idle_i && (run_n >= thr_i);
  end

  // evaluation window and continuous-idle run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ei_cnt_q <= '0;
      acc_q    <= '0;
      run_q    <= '0;
    end else if (clr_i) begin
      ei_cnt_q <= '0;
      acc_q    <= '0;
      run_q    <= '0;
    end else begin
      if (!idle_i)     run_q <= '0;
      else if (tick_i) run_q <= run_n;
      if (tick_i) begin
        if (ei_last) begin
          ei_cnt_q <= '0;
          acc_q    <= '0;
        end else begin
          ei_cnt_q <= ei_cnt_n;
          acc_q    <= acc_n;
        end
      end
    end
  end

  // power-gate hysteresis
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      pg_q   <= 1'b0;
    end else if (!hgate_i || !idle_i) begin
      hcnt_q <= '0;
      pg_q   <= 1'b0;
    end else if (tick_i) begin
      hcnt_q <= hcnt_n;
      if (hcnt_n >= hyst_i) pg_q <= 1'b1;
    end
  end

  assign pg_o = pg_q;
endmodule

// File: rtl/ipc_state_seq.sv
`timescale 1ns/1ps
module ipc_state_seq
  import ipc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       busy_i,
  input  logic       auto_en_i,
  input  logic       to_sel_i,
  input  logic       force_en_i,
  input  logic [2:0] tgt_i,
  input  logic       enter_ei_i,
  input  logic       enter_to_i,
  output pstate_e    state_o
);
  pstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (busy_i) begin
      state_d = PS_ACT;
    end else if (force_en_i) begin
      case (tgt_i)
        3'd4:    if (tick_i) state_d = PS_NORM;
        3'd5:    if (tick_i) state_d = PS_DEEP;
        3'd6:    if (tick_i) state_d = PS_DEEPEST;
        default: state_d = PS_ACT;
      endcase
    end else if (auto_en_i) begin
      if (state_q == PS_ACT && (to_sel_i ? enter_to_i : enter_ei_i))
        state_d = PS_NORM;
    end else begin
      state_d = PS_ACT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_ACT;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/idle_pwr_ctrl.sv
`timescale 1ns/1ps
module idle_pwr_ctrl
  import ipc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 256,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned RST_IVAL = 125000,
  parameter int unsigned RST_THR  = 50000,
  parameter int unsigned RST_HYST = 25,
  parameter logic [31:0] RST_WRL  = 32'h0036_0055
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        busy_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [1:0]  pstate_o,
  output logic        pg_req_o
);
  logic [3:0]       ctrl_q;
  logic [2:0]       tgt_q;
  logic [CNT_W-1:0] ival_q, thr_q, hyst_q;
  logic [31:0]      wrl_q;
  logic             tick, enter_ei, enter_to, pg;
  logic             force_en, auto_en, clr;
  pstate_e          state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tgt_q  <= '0;
      ival_q <= CNT_W'(RST_IVAL);
      thr_q  <= CNT_W'(RST_THR);
      hyst_q <= CNT_W'(RST_HYST);
      wrl_q  <= RST_WRL;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  ctrl_q <= wdata_i[3:0];
        A_STATE: tgt_q  <= wdata_i[TGT_LSB +: 3];
        A_IVAL:  ival_q <= wdata_i[CNT_W-1:0];
        A_THR:   thr_q  <= wdata_i[CNT_W-1:0];
        A_HYST:  hyst_q <= wdata_i[CNT_W-1:0];
        A_WRL:   wrl_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[3:0] = ctrl_q;
      A_STATE: begin
        rdata_o[TGT_LSB +: 3] = tgt_q;
        rdata_o[ST_LSB +: 2]  = state;
      end
      A_IVAL:  rdata_o[CNT_W-1:0] = ival_q;
      A_THR:   rdata_o[CNT_W-1:0] = thr_q;
      A_HYST:  rdata_o[CNT_W-1:0] = hyst_q;
      A_WRL:   rdata_o = wrl_q;
      default: ;
    endcase
  end

  // software override: sleep-enable alone
  assign force_en = (ctrl_q == 4'b0010);
  assign auto_en  = ctrl_q[CB_HW] && ctrl_q[CB_SLP] && (ctrl_q[CB_EI] || ctrl_q[CB_TO]);
  assign clr      = !auto_en || (state != PS_ACT);

  ipc_tick_gen #(.DIV(TICK_DIV)) tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ipc_idle_timers #(.CW(CNT_W)) tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .idle_i    (!busy_i),
    .clr_i     (clr),
    .hgate_i   (ctrl_q[CB_SLP]),
    .ival_i    (ival_q),
    .thr_i     (thr_q),
    .hyst_i    (hyst_q),
    .enter_ei_o(enter_ei),
    .enter_to_o(enter_to),
    .pg_o      (pg)
  );

  ipc_state_seq seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .busy_i    (busy_i),
    .auto_en_i (auto_en),
    .to_sel_i  (ctrl_q[CB_TO]),
    .force_en_i(force_en),
    .tgt_i     (tgt_q),
    .enter_ei_i(enter_ei),
    .enter_to_i(enter_to),
    .state_o   (state)
  );

  assign pstate_o = state;
  assign pg_req_o = pg;
endmodule

// File: rtl/ipc_chk.sv
`timescale 1ns/1ps
module ipc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       busy_i,
  input logic [1:0] pstate_i,
  input logic       pg_req_i,
  input logic [3:0] ctrl_i,
  input logic [2:0] tgt_i
);
  // R8
  busy_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> pstate_i == 2'd0);

  // R9
  pg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !pg_req_i);

  // R2
  tick_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_i == 2'd0 && !tick_i) |=> pstate_i == 2'd0);

  // R6
  no_sleep_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[1] |=> (pstate_i == 2'd0 && !pg_req_i));

  // R7
  force_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy_i && ctrl_i == 4'b0010 && tgt_i == 3'd6) |=> pstate_i == 2'd3);
endmodule

bind idle_pwr_ctrl ipc_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick),
  .busy_i  (busy_i),
  .pstate_i(pstate_o),
  .pg_req_i(pg_req_o),
  .ctrl_i  (ctrl_q),
  .tgt_i   (tgt_q)
);

// File: tb/idle_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module idle_pwr_ctrl_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pstate;
  logic        pg_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  idle_pwr_ctrl #(.TICK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pstate_o(pstate), .pg_req_o(pg_req)
  );

  typedef struct packed {
    logic [3:0] ctrl;
    logic [2:0] tgt;
    logic [7:0] ival;
    logic [7:0] thr;
    logic [7:0] wt;
    logic [1:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'b1011, 3'd0, 8'd0,   8'd8, 8'd5,  2'd0, 4'd3}, // R3 R2: too early
    '{4'b1011, 3'd0, 8'd0,   8'd8, 8'd11, 2'd1, 4'd3}, // R3: reached
    '{4'b0111, 3'd0, 8'd6,   8'd4, 8'd4,  2'd0, 4'd4}, // R4: before interval end
    '{4'b0111, 3'd0, 8'd6,   8'd4, 8'd8,  2'd1, 4'd4}, // R4: at interval end
    '{4'b0111, 3'd0, 8'd6,   8'd7, 8'd20, 2'd0, 4'd4}, // R4: accumulator cleared each interval
    '{4'b1111, 3'd0, 8'd100, 8'd5, 8'd8,  2'd1, 4'd5}, // R5
    '{4'b0110, 3'd0, 8'd2,   8'd1, 8'd10, 2'd0, 4'd6}, // R6: no hw bit
    '{4'b1001, 3'd0, 8'd0,   8'd1, 8'd10, 2'd0, 4'd6}, // R6: no sleep bit
    '{4'b0010, 3'd4, 8'd0,   8'd0, 8'd2,  2'd1, 4'd7}, // R7
    '{4'b0010, 3'd5, 8'd0,   8'd0, 8'd2,  2'd2, 4'd7}, // R7
    '{4'b0010, 3'd6, 8'd0,   8'd0, 8'd2,  2'd3, 4'd7}, // R7
    '{4'b0010, 3'd7, 8'd0,   8'd0, 8'd2,  2'd0, 4'd7}  // R7: invalid target
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic quiesce();
    busy = 1'b1;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd4, 32'd255);
  endtask

  // write control and drop busy together
  task automatic start(input logic [3:0] c);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = {28'd0, c}; busy = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pstate == 2'd0, "R1 pstate", pstate, 0);
    chk(pg_req == 1'b0, "R1 pg_req", pg_req, 0);
    rd(3'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(3'd2, d); chk(d == 125000, "R1 interval", d, 125000);
    rd(3'd3, d); chk(d == 50000, "R1 threshold", d, 50000);
    rd(3'd4, d); chk(d == 25, "R1 hysteresis", d, 25);
    rd(3'd5, d); chk(d == 32'h0036_0055, "R1 wake limit", d, 32'h0036_0055);
    rd(3'd1, d); chk(d[9:8] == 0, "R12 reset status", d[9:8], 0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      quiesce();
      wr(3'd2, {24'd0, VECS[i].ival});
      wr(3'd3, {24'd0, VECS[i].thr});
      wr(3'd1, {25'd0, VECS[i].tgt, 4'd0});
      start(VECS[i].ctrl);
      repeat (VECS[i].wt * DIV - 1) @(negedge clk);
      n_chk++;
      if (pstate != VECS[i].exp) begin
        n_fail++;
        $display("FAIL vector %0d R%0d actual=%0d expected=%0d", i, VECS[i].req, pstate, VECS[i].exp);
      end
    end

    // R8 wake and counter clear
    quiesce();
    wr(3'd3, 32'd8);
    start(4'b1011);
    wait_ticks(11);
    chk(pstate == 2'd1, "R8 asleep before busy", pstate, 1);
    busy = 1'b1;
    @(negedge clk);
    chk(pstate == 2'd0, "R8 wake", pstate, 0);
    busy = 1'b0;
    wait_ticks(5);
    chk(pstate == 2'd0, "R8 count restarted", pstate, 0);
    wait_ticks(6);
    chk(pstate == 2'd1, "R8 re-entry", pstate, 1);

    // R9 hysteresis
    quiesce();
    wr(3'd3, 32'd200);
    wr(3'd4, 32'd3);
    start(4'b1011);
    wait_ticks(1);
    chk(pg_req == 1'b0, "R9 pg early", pg_req, 0);
    wait_ticks(4);
    chk(pg_req == 1'b1, "R9 pg after hysteresis", pg_req, 1);
    busy = 1'b1;
    @(negedge clk);
    chk(pg_req == 1'b0, "R9 pg drop on busy", pg_req, 0);

    // R12 status readback, R10 forced off
    quiesce();
    wr(3'd4, 32'd1);
    wr(3'd1, 32'h50);
    start(4'b0010);
    wait_ticks(3);
    rd(3'd1, d);
    chk(d[9:8] == 2'd2, "R12 status deep", d[9:8], 2);
    chk(d[6:4] == 3'd5, "R12 target readback", d[6:4], 5);
    chk(pstate == 2'd2, "R12 pstate deep", pstate, 2);
    chk(pg_req == 1'b1, "R10 pg before off", pg_req, 1);
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd0);
    @(negedge clk);
    chk(pstate == 2'd0, "R10 awake", pstate, 0);
    chk(pg_req == 1'b0, "R10 pg off", pg_req, 0);

    // R11 wake rate limit halves
    wr(3'd5, 32'h1234_ABCD);
    rd(3'd5, d);
    chk(d[31:16] == 16'h1234, "R11 upper", d[31:16], 16'h1234);
    chk(d[15:0] == 16'hABCD, "R11 lower", d[15:0], 16'hABCD);

    // R13 busy on the entry tick
    quiesce();
    wr(3'd3, 32'd1);
    start(4'b1011);
    begin
      int guard = 0;
      while (pstate != 2'd1 && guard < 4 * DIV) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(pstate == 2'd1, "R13 phase found", pstate, 1);
    busy = 1'b1;
    @(negedge clk);
    busy = 1'b0;
    repeat (DIV - 2) @(negedge clk);
    busy = 1'b1;
    @(negedge clk);
    chk(pstate == 2'd0, "R13 busy wins on tick", pstate, 0);
    busy = 1'b0;
    wait_ticks(1);
    chk(pstate == 2'd1, "R13 enters next tick", pstate, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule